// File: doc/BRIEF.md
# Parallel IO Bank Controller

This block controls a bank of 32 general-purpose pins through a small word-addressed register bus. Every per-pin setting lives in its own 32-bit attribute word. Software never writes an attribute word directly. It writes a 1 to a "raise" word to set chosen bits, or a 1 to a "drop" word to clear them, and reads the result back from a status word. No read-modify-write sequence is ever needed, so two agents can change different pins without getting in each other's way.

For each pin the block chooses who owns the pad. Under port control the bank's own output-data and output-enable bits drive it. Under peripheral control one of two peripheral functions, A or B, drives it. The block also sets the pad's pull-up and can run the pin as an open-drain (multi-drive) output. A level word returns the live state of every pad. The register bus and the pad signals are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure: every write takes effect in one cycle and every read answers in one cycle.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is under port control and is an input (pad_oe 0). Its output data is 0, its pull-up is enabled (pad_pu 1), open-drain is off and peripheral A is selected.
- R2: A write to a raise word sets exactly the attribute bits where wdata is 1. A write to a drop word clears exactly those bits. Bits where wdata is 0 keep their value, and nothing changes in a cycle without wr_en. The new value is visible on the pads right after the write edge.
- R3: The word address map is as follows. Port ownership: raise 0, drop 1, status 2. Output enable: 3, 4, 5. Output data: 6, 7, 8. Pull-up enable: 9, 10, status 11. Open-drain: 12, 13, 14. Peripheral select: route-to-A 15, route-to-B 16, status 17 (1 = B). Pad level: 18. A read returns the value on rdata one cycle after the rd_en edge. Raise, drop and route words, and addresses 19 to 31, read 0. rdata is 0 in any cycle that follows no read.
- R4: A pin whose port-status bit is 1 drives pad_out from its output-data bit and pad_oe from its output-enable bit.
- R5: Dropping a pin's port bit hands the pad to a peripheral. pad_out and pad_oe then come from per_b_out/per_b_oe when the pin's select bit is 1, and from per_a_out/per_a_oe when it is 0.
- R6: Output data can be changed while a pin's output is disabled. The stored value appears on pad_out, driven, as soon as output enable is set.
- R7: The pull-up status word reads 1 for a pin whose pull-up is disabled and 0 for one whose pull-up is enabled. pad_pu is 1 exactly when the pull-up is enabled.
- R8: With open-drain on, a pin never drives high. Whatever source owns the pad, pad_oe is forced to 0 whenever the source's output value is 1.
- R9: A read of the pad-level word returns pad_in as sampled at the read edge, for every pin and whatever its direction or owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Word address for read and write |
| wdata | input | 32 | Write data, one bit per pin |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after rd_en |
| per_a_out | input | 32 | Peripheral A output value per pin |
| per_a_oe | input | 32 | Peripheral A output enable per pin |
| per_b_out | input | 32 | Peripheral B output value per pin |
| per_b_oe | input | 32 | Peripheral B output enable per pin |
| pad_in | input | 32 | Live pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output driver enable |
| pad_pu | output | 32 | Pad pull-up enable |

## Verification
A write updates the attribute registers at the edge where wr_en is sampled. pad_out, pad_oe and pad_pu are combinational from those registers and from the peripheral inputs, so they are due just after that same edge. rdata is due one edge after rd_en is sampled, and it returns to 0 at the next edge if no read follows. Stimulus changes only on falling edges. The reference model takes in inputs at each rising edge and compares every output one time step after it. Directed checks read status words in the cycle after the read strobe.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W   = 5;
  localparam int NUM_ATTR = 6;
  // attribute slots
  localparam int A_PORT = 0;
  localparam int A_OE   = 1;
  localparam int A_DAT  = 2;
  localparam int A_PUEN = 3;
  localparam int A_OD   = 4;
  localparam int A_SELB = 5;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 5'd18;

  // select slot: address 15 routes to A (clears), 16 routes to B (sets)
  function automatic logic [ADDR_W-1:0] raise_addr(int a);
    if (a == A_SELB) return 5'd16;
    return 5'(3 * a);
  endfunction

  function automatic logic [ADDR_W-1:0] drop_addr(int a);
    if (a == A_SELB) return 5'd15;
    return 5'(3 * a + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] stat_addr(int a);
    return 5'(3 * a + 2);
  endfunction

  function automatic logic reset_bit(int a);
    return (a == A_PORT) || (a == A_PUEN);
  endfunction
endpackage

// File: rtl/pio_attr_reg.sv
module pio_attr_reg
  import pio_pkg::*;
#(
  parameter int                W      = 32,
  parameter logic              RST    = 1'b0,
  parameter logic [ADDR_W-1:0] SET_AD = '0,
  parameter logic [ADDR_W-1:0] CLR_AD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        q <= {W{RST}};
    else if (wr_en && addr == SET_AD)  q <= q | wdata;
    else if (wr_en && addr == CLR_AD)  q <= q & ~wdata;
  end
endmodule

// File: rtl/pio_pad_route.sv
module pio_pad_route #(
  parameter int W = 32
) (
  input  logic [W-1:0] port_q,
  input  logic [W-1:0] oe_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] od_q,
  input  logic [W-1:0] selb_q,
  input  logic [W-1:0] per_a_out,
  input  logic [W-1:0] per_a_oe,
  input  logic [W-1:0] per_b_out,
  input  logic [W-1:0] per_b_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic src_out, src_oe;
    always_comb begin
      if (port_q[i]) begin
        src_out = dat_q[i];
        src_oe  = oe_q[i];
      end else if (selb_q[i]) begin
        src_out = per_b_out[i];
        src_oe  = per_b_oe[i];
      end else begin
        src_out = per_a_out[i];
        src_oe  = per_a_oe[i];
      end
    end
    assign pad_out[i] = src_out;
    // open drain: release instead of driving high
    assign pad_oe[i]  = src_oe & ~(od_q[i] & src_out);
  end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [NUM_ATTR-1:0][W-1:0] attr_q,
  input  logic [W-1:0]               pad_in,
  input  logic [ADDR_W-1:0]          addr,
  output logic [W-1:0]               rd_val
);
  always_comb begin
    rd_val = '0;
    for (int a = 0; a < NUM_ATTR; a++) begin
      if (addr == stat_addr(a))
        rd_val = (a == A_PUEN) ? ~attr_q[a] : attr_q[a];
    end
    if (addr == ADR_LEVEL) rd_val = pad_in;
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic              rd_en,
  output logic [NPIN-1:0]   rdata,
  input  logic [NPIN-1:0]   per_a_out,
  input  logic [NPIN-1:0]   per_a_oe,
  input  logic [NPIN-1:0]   per_b_out,
  input  logic [NPIN-1:0]   per_b_oe,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu
);
  logic [NUM_ATTR-1:0][NPIN-1:0] attr_q;
  logic [NPIN-1:0] rd_val;
  logic [NPIN-1:0] port_q, oe_q, dat_q, od_q, selb_q;

  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
    pio_attr_reg #(
      .W      (NPIN),
      .RST    (reset_bit(a)),
      .SET_AD (raise_addr(a)),
      .CLR_AD (drop_addr(a))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .q     (attr_q[a])
    );
  end

  assign port_q = attr_q[A_PORT];
  assign oe_q   = attr_q[A_OE];
  assign dat_q  = attr_q[A_DAT];
  assign od_q   = attr_q[A_OD];
  assign selb_q = attr_q[A_SELB];
  assign pad_pu = attr_q[A_PUEN];

  pio_pad_route #(.W(NPIN)) u_route (
    .port_q    (port_q),
    .oe_q      (oe_q),
    .dat_q     (dat_q),
    .od_q      (od_q),
    .selb_q    (selb_q),
    .per_a_out (per_a_out),
    .per_a_oe  (per_a_oe),
    .per_b_out (per_b_out),
    .per_b_oe  (per_b_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  pio_rd_mux #(.W(NPIN)) u_rd (
    .attr_q (attr_q),
    .pad_in (pad_in),
    .addr   (addr),
    .rd_val (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPIN-1:0]   wdata,
  input logic              rd_en,
  input logic [NPIN-1:0]   rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   port_q,
  input logic [NPIN-1:0]   oe_q,
  input logic [NPIN-1:0]   od_q,
  input logic [NPIN-1:0]   selb_q,
  input logic [NPIN-1:0]   per_a_oe
);
  AST_OE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd3) |=> ((oe_q & $past(wdata)) == $past(wdata)));  // R2
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd4) |=> ((oe_q & $past(wdata)) == '0));  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(port_q) && $stable(oe_q) && $stable(od_q) && $stable(selb_q)));  // R2
  AST_PERIPH_A_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~port_q & ~selb_q & ~od_q & per_a_oe) == (~port_q & ~selb_q & ~od_q & pad_oe)));  // R5
  AST_OPEN_DRAIN_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_q & pad_oe & pad_out) == '0));  // R8
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));  // R3
endmodule

bind pio_bank pio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .port_q   (port_q),
  .oe_q     (oe_q),
  .od_q     (od_q),
  .selb_q   (selb_q),
  .per_a_oe (per_a_oe)
);

// File: tb/pio_bank_tb.sv
`timescale 1ns/1ps
module pio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0, pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  pio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
    .per_b_out(per_b_out), .per_b_oe(per_b_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // behavioural reference state
  logic [31:0] m_port, m_oe, m_dat, m_pu, m_od, m_selb, m_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [4:0] a);
    case (a)
      5'd2:  return m_port;
      5'd5:  return m_oe;
      5'd8:  return m_dat;
      5'd11: return ~m_pu;
      5'd14: return m_od;
      5'd17: return m_selb;
      5'd18: return pad_in;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_out();
    return (m_port & m_dat) | (~m_port & m_selb & per_b_out) | (~m_port & ~m_selb & per_a_out);
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] s;
    s = (m_port & m_oe) | (~m_port & m_selb & per_b_oe) | (~m_port & ~m_selb & per_a_oe);
    return s & ~(m_od & exp_out());
  endfunction

  // model update on each rising edge, then compare shortly after it
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_port = '1; m_oe = '0; m_dat = '0; m_pu = '1; m_od = '0; m_selb = '0; m_rd = '0;
    end else begin
      m_rd = rd_en ? model_read(addr) : 32'h0;
      if (wr_en) begin
        case (addr)
          5'd0:  m_port |= wdata;   5'd1:  m_port &= ~wdata;
          5'd3:  m_oe   |= wdata;   5'd4:  m_oe   &= ~wdata;
          5'd6:  m_dat  |= wdata;   5'd7:  m_dat  &= ~wdata;
          5'd9:  m_pu   |= wdata;   5'd10: m_pu   &= ~wdata;
          5'd12: m_od   |= wdata;   5'd13: m_od   &= ~wdata;
          5'd16: m_selb |= wdata;   5'd15: m_selb &= ~wdata;
          default: ;
        endcase
      end
    end
    #1;
    if (rst_n && !done) begin
      chk("R4/R5 pad_out vs model", pad_out, exp_out());
      chk("R8/R6 pad_oe vs model", pad_oe, exp_oe());
      chk("R7 pad_pu vs model", pad_pu, m_pu);
      chk("R3 rdata vs model", rdata, m_rd);
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    chk("R1 pad_pu reset", pad_pu, 32'hFFFF_FFFF);
    rd_chk(5'd2,  32'hFFFF_FFFF, "R1 port status");
    rd_chk(5'd8,  32'h0, "R1 data status");
    rd_chk(5'd11, 32'h0, "R1 pull-up status");
    rd_chk(5'd17, 32'h0, "R1 select status");
    // R2 raise/drop
    wr(5'd3, 32'h0000_00FF);
    wr(5'd6, 32'h0F0F_0F0F);
    wr(5'd7, 32'h0000_0F00);
    rd_chk(5'd8, 32'h0F0F_000F, "R2 data after raise+drop");
    rd_chk(5'd5, 32'h0000_00FF, "R2 oe after raise");
    chk("R4 pad_out port data", pad_out, 32'h0F0F_000F);
    // R6 data while output disabled
    wr(5'd6, 32'h00FF_0000);
    chk("R6 disabled pin not driven", pad_oe & 32'h00FF_0000, 32'h0);
    wr(5'd3, 32'h00FF_0000);
    chk("R6 stored data driven", pad_oe & pad_out & 32'h00FF_0000, 32'h00FF_0000);
    // R7 pull-up
    wr(5'd10, 32'hF000_0000);
    rd_chk(5'd11, 32'hF000_0000, "R7 pull-up status inverted");
    chk("R7 pad_pu", pad_pu, 32'h0FFF_FFFF);
    // R8 open drain on pins 0..3 holding data 1
    wr(5'd12, 32'h0000_000F);
    chk("R8 high released", pad_oe & 32'hF, 32'h0);
    wr(5'd7, 32'h0000_0001);
    chk("R8 low driven", pad_oe & 32'hF, 32'h1);
    // R5 peripheral routing
    per_a_out = 32'h0000_5500; per_a_oe = 32'h0000_FF00;
    per_b_out = 32'h0000_AA00; per_b_oe = 32'h0000_0F00;
    wr(5'd1, 32'h0000_FF00);
    wr(5'd16, 32'h0000_F000);
    rd_chk(5'd17, 32'h0000_F000, "R5 select status");
    chk("R5 pad_out mix", pad_out & 32'h0000_FF00, 32'h0000_A500);
    chk("R5 pad_oe mix", pad_oe & 32'h0000_FF00, 32'h0000_0F00);
    wr(5'd15, 32'h0000_3000);
    rd_chk(5'd17, 32'h0000_C000, "R5 route back to A");
    // R9 pad level
    @(negedge clk); pad_in = 32'hA5A5_5A5A;
    rd_chk(5'd18, 32'hA5A5_5A5A, "R9 pad level");
    // R3 write-only and unmapped reads
    rd_chk(5'd0,  32'h0, "R3 raise word reads 0");
    rd_chk(5'd16, 32'h0, "R3 route word reads 0");
    rd_chk(5'd25, 32'h0, "R3 unmapped reads 0");
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en = $urandom_range(0, 1) == 1;
      rd_en = $urandom_range(0, 2) == 0;
      addr = 5'($urandom_range(0, 20));
      wdata = $urandom;
      per_a_out = $urandom; per_a_oe = $urandom;
      per_b_out = $urandom; per_b_oe = $urandom;
      pad_in = $urandom;
    end
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule